// File: doc/BRIEF.md
# USB Device Connection State Controller

This block holds the attachment and enumeration state of a USB device core. It starts out detached, with the pull-up off and every endpoint closed. A software "ready" command attaches the device at full speed. A bus reset from the line monitor starts a high-speed negotiation window. Software then writes the assigned address through a state-word write. Chirp waveforms, packet traffic and the control-transfer engine are outside the block. They appear here only as strobes: a bus-reset pulse, a chirp-success pulse and a status-stage-done pulse.

The device state, the speed mode and the address are all registered. Each one changes on the clock edge that samples the event causing it. A 16-bit read-back word packs the three together for software.

Top module: `usb_link_state`

## Requirements
- R1: While reset is active and just after it, the device is Disconnected. The pull-up is off, the mode is full-speed, the address is 0, no endpoint is ready and the read-back word is 0.
- R2: While Disconnected, only `ready_cmd` has an effect. It moves the device to Default in full-speed mode and turns the pull-up on. Bus resets, chirp pulses and writes are ignored.
- R3: In Default before any bus reset, `chirp_ok` leaves the mode unchanged. A repeated `ready_cmd` while connected changes nothing.
- R4: A bus reset while connected puts the device in Default, sets the address to 0, discards any recorded status-stage completion and sets the mode to chirp-in-progress.
- R5: A `chirp_ok` pulse in the k-th cycle after the bus-reset cycle, for 1 ≤ k ≤ CHIRP_TIMEOUT, sets the mode to high-speed and raises `hs_mode`.
- R6: If no `chirp_ok` arrives, the mode becomes full-speed after CHIRP_TIMEOUT cycles of chirp. A `chirp_ok` that arrives later is ignored.
- R7: A write in Default is accepted only if a `status_done` pulse came before it and no bus reset or accepted write came in between. The write must carry 3'b010 in bits [10:8] and the address in bits [6:0]. An accepted write moves the device to Addressed and latches the address.
- R8: The following writes are ignored and leave the state and the address unchanged: a write with no status-stage completion recorded, and a write whose bits [10:8] differ from 3'b010.
- R9: The read-back word holds the mode in bits [13:12] (00 full-speed, 01 high-speed, 10 chirp). It holds the state in bits [10:8] (000 Disconnected, 001 Default, 010 Addressed) and the address in bits [6:0]. All other bits read 0.
- R10: Endpoint 0 is ready in Default and in Addressed. Every other endpoint is ready only in Addressed.
- R11: A bus reset while Addressed clears the stored address to 0 and returns the device to Default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ready_cmd | input | 1 | Software attach command pulse |
| bus_reset | input | 1 | Bus reset detected pulse |
| chirp_ok | input | 1 | Chirp handshake succeeded pulse |
| status_done | input | 1 | Control transfer status stage completed pulse |
| reg_wr | input | 1 | State-word write strobe |
| reg_wdata | input | 16 | State-word write data |
| pullup_en | output | 1 | Data-line pull-up enable |
| hs_mode | output | 1 | High-speed mode active |
| dev_state | output | 2 | 0 Disconnected, 1 Default, 2 Addressed |
| dev_addr | output | 7 | Assigned device address |
| ep_ready | output | NUM_EP | Per-endpoint ready flags |
| state_word | output | 16 | Read-back of mode, state and address |

## Verification
The hardest case to reach is a chirp success at the exact edge where the timeout would fire. The handshake pulse must land in a precise cycle relative to the bus reset. To get there, the bench repeats a bus reset and delays the `chirp_ok` pulse by every offset from 1 to beyond CHIRP_TIMEOUT. It checks the mode after each cycle of every run. The address sweep covers each of the 128 addresses. Before each accepted write it tries a write with no recorded status stage and a write with a wrong state code.

// File: rtl/usb_link_state.sv
module usb_link_state #(
  parameter int NUM_EP        = 4,
  parameter int CHIRP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_cmd,
  input  logic              bus_reset,
  input  logic              chirp_ok,
  input  logic              status_done,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic              pullup_en,
  output logic              hs_mode,
  output logic [1:0]        dev_state,
  output logic [6:0]        dev_addr,
  output logic [NUM_EP-1:0] ep_ready,
  output logic [15:0]       state_word
);

  localparam int TW = $clog2(CHIRP_TIMEOUT + 1);
  localparam logic [1:0] MODE_FS = 2'b00, MODE_HS = 2'b01, MODE_CHIRP = 2'b10;
  localparam logic [2:0] ADDR_CODE = 3'b010;

  typedef enum logic [1:0] {ST_DISC = 2'd0, ST_DFLT = 2'd1, ST_ADDR = 2'd2} link_st_t;

  link_st_t      state;
  logic [1:0]    mode;
  logic [6:0]    addr_q;
  logic          status_seen;
  logic [TW-1:0] chirp_timer;
  logic          addr_accept;

  assign addr_accept = (state == ST_DFLT) && reg_wr && status_seen &&
                       (reg_wdata[10:8] == ADDR_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_DISC;
      mode        <= MODE_FS;
      addr_q      <= '0;
      status_seen <= 1'b0;
      chirp_timer <= '0;
    end else if (state == ST_DISC) begin
      if (ready_cmd) begin
        state <= ST_DFLT;
        mode  <= MODE_FS;
      end
    end else if (bus_reset) begin
      state       <= ST_DFLT;
      mode        <= MODE_CHIRP;
      addr_q      <= '0;
      status_seen <= 1'b0;
      chirp_timer <= '0;
    end else begin
      if (mode == MODE_CHIRP) begin
        if (chirp_ok)
          mode <= MODE_HS;
        else if (chirp_timer == TW'(CHIRP_TIMEOUT - 1))
          mode <= MODE_FS;
        else
          chirp_timer <= chirp_timer + 1'b1;
      end
      if (status_done) status_seen <= 1'b1;
      if (addr_accept) begin
        state       <= ST_ADDR;
        addr_q      <= reg_wdata[6:0];
        status_seen <= 1'b0;
      end
    end
  end

  assign pullup_en  = (state != ST_DISC);
  assign hs_mode    = (mode == MODE_HS);
  assign dev_state  = state;
  assign dev_addr   = addr_q;
  assign state_word = {2'b00, mode, 1'b0, 1'b0, state, 1'b0, addr_q};

  assign ep_ready[0] = (state != ST_DISC);
  for (genvar i = 1; i < NUM_EP; i++) begin : g_ep
    assign ep_ready[i] = (state == ST_ADDR);
  end

  // R2
  attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISC && ready_cmd) |=> (state == ST_DFLT && mode == MODE_FS));

  // R2
  detached_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DISC && !ready_cmd) |=> (state == ST_DISC && addr_q == 7'd0));

  // R4
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DISC && bus_reset) |=>
      (state == ST_DFLT && addr_q == 7'd0 && mode == MODE_CHIRP));

  // R5
  chirp_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DISC && !bus_reset && mode == MODE_CHIRP && chirp_ok) |=> (mode == MODE_HS));

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_timer < TW'(CHIRP_TIMEOUT));

  // R7
  addr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ADDR) |=> (state != ST_ADDR || $past(status_seen && reg_wr)));

endmodule

// File: tb/usb_link_state_bench.sv
module usb_link_state_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 4;
  localparam int T   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready_cmd = 0, bus_reset = 0, chirp_ok = 0, status_done = 0, reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic pullup_en, hs_mode;
  logic [1:0] dev_state;
  logic [6:0] dev_addr;
  logic [NEP-1:0] ep_ready;
  logic [15:0] state_word;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_link_state #(.NUM_EP(NEP), .CHIRP_TIMEOUT(T)) u_usb_link_state (
    .clk(clk), .rst_n(rst_n), .ready_cmd(ready_cmd), .bus_reset(bus_reset),
    .chirp_ok(chirp_ok), .status_done(status_done), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .pullup_en(pullup_en), .hs_mode(hs_mode),
    .dev_state(dev_state), .dev_addr(dev_addr), .ep_ready(ep_ready),
    .state_word(state_word));

  function automatic logic [15:0] word(input int m, input int s, input int a);
    return 16'((m << 12) | (s << 8) | a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ready_cmd = 0; bus_reset = 0; chirp_ok = 0; status_done = 0; reg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {pullup_en, hs_mode, ep_ready}, '0);
    check("R1", state_word, 16'h0000);
    rst_n = 1;
    tick();
    check("R1", state_word, 16'h0000);

    // R2 events other than ready ignored while detached
    bus_reset = 1; tick();
    chirp_ok = 1; tick();
    status_done = 1; tick();
    reg_wr = 1; reg_wdata = 16'h0205; tick();
    check("R2", {pullup_en, ep_ready, state_word}, {1'b0, 4'b0, 16'h0000});

    ready_cmd = 1; tick();
    check("R2", {pullup_en, hs_mode, dev_state}, {1'b1, 1'b0, 2'd1});
    check("R10", ep_ready, 4'b0001);
    check("R9", state_word, word(0, 1, 0));

    // R3 chirp_ok and repeated ready ignored before bus reset
    chirp_ok = 1; tick();
    check("R3", state_word, word(0, 1, 0));
    ready_cmd = 1; tick();
    check("R3", state_word, word(0, 1, 0));

    // R5/R6 chirp sweep over every offset
    for (int k = 1; k <= T + 2; k++) begin
      bus_reset = 1; tick();
      check("R4", state_word, word(2, 1, 0));
      for (int j = 1; j < k; j++) begin
        tick();
        check("R6", state_word, word((j < T) ? 2 : 0, 1, 0));
      end
      chirp_ok = 1; tick();
      if (k <= T) begin
        check("R5", {hs_mode, state_word}, {1'b1, word(1, 1, 0)});
      end else begin
        check("R6", {hs_mode, state_word}, {1'b0, word(0, 1, 0)});
      end
    end

    // R7/R8/R10/R11 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_reset = 1; tick();
      reg_wr = 1; reg_wdata = 16'(16'h0200 | a); tick();
      check("R8", {dev_state, dev_addr}, {2'd1, 7'd0});
      status_done = 1; tick();
      reg_wr = 1; reg_wdata = 16'(16'h0300 | a); tick();
      check("R8", {dev_state, dev_addr}, {2'd1, 7'd0});
      reg_wr = 1; reg_wdata = 16'(16'h0200 | a); tick();
      check("R7", {dev_state, dev_addr}, {2'd2, 7'(a)});
      check("R10", ep_ready, 4'b1111);
      check("R9", state_word[11:0], word(0, 2, a) & 16'h0fff);
      bus_reset = 1; tick();
      check("R11", {dev_state, dev_addr, ep_ready}, {2'd1, 7'd0, 4'b0001});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule